// File: doc/BRIEF.md
# Dynamic VID Reference Controller

This block turns a processor voltage-identification (VID) code into the digital reference code that feeds a regulator's voltage DAC. The VID bus is sampled on a sub-cycle strobe, nominally six strobes per switching cycle. A code is taken on only after three consecutive strobes have read the same value and that value differs from the code currently in force. A linear decode then maps the accepted code to a target in 12.5 mV units. The exact voltage tables and the analog filtering are outside this block.

Two behaviours are selected by `mode_i`. In jump mode the reference goes to the new target at once. In slew mode the reference first waits half a switching cycle. It then moves one unit toward the target on each phase tick until it arrives. If the target moves while a ramp is running, the ramp continues toward the new value without a new wait. `busy_o` flags any difference between the reference and the target. After reset the reference is loaded straight from the decoded VID on the bus, with no ramp.

Top module: `vid_ref_ctrl`

## Requirements
- R1: On the first clock after reset is released, `ref_o` takes the decoded value of the current `vid_i`, and `busy_o` is low.
- R2: A new VID value is accepted only on a sample strobe, and only when it is the third consecutive strobe reading that value and the value differs from the accepted code. Two matching strobes followed by a different value cause no change.
- R3: In jump mode (`mode_i`=0), `ref_o` equals the new target one clock after the accepting strobe edge.
- R4: In jump mode, a jump of more than one unit is applied in a single update with no limiting.
- R5: In slew mode (`mode_i`=1), no step is taken until three sample strobes (half of a six-strobe cycle) have passed since the target moved away from the reference.
- R6: In slew mode, `ref_o` changes only on a clock where `phase_tick_i` was high, and by exactly one unit. A ramp of N units takes N or N+1 phase ticks from the rise of `busy_o` to the last step.
- R7: `busy_o` is high exactly while the reference differs from the target, and `ref_o` holds while `busy_o` is low.
- R8: A target change during a slew ramp redirects the ramp, with no extra wait and no reload of the reference.
- R9: Decode: jump mode target = 40 + code, and slew mode target = 140 - 2 × code, in 12.5 mV units.
- R10: Switching `mode_i` from 0 to 1 with an unchanged code starts a ramp to the slew-mode target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_tick_i | input | 1 | One-clock pulse, once per switching cycle |
| sample_stb_i | input | 1 | One-clock VID sample strobe, six per cycle |
| mode_i | input | 1 | 0 = jump mode, 1 = slew mode |
| vid_i | input | VID_W | Requested VID code |
| ref_o | output | REF_W | Reference code, 12.5 mV units |
| busy_o | output | 1 | Reference differs from target |

## Verification
The hardest case to reach is a retarget in the middle of a ramp. The new code has to pass the three-strobe filter while the reference is still stepping. The bench changes the VID again as soon as it sees the first step of a short ramp. It then checks that the total step count and the phase ticks used match a single ramp from the original start to the new end. The glitch case is timed on strobe edges: the bench counts the applied strobes and restores the old code right after the second one.

// File: rtl/vid_ref_pkg.sv
package vid_ref_pkg;

  typedef enum logic [1:0] {
    SL_IDLE = 2'd0,
    SL_WAIT = 2'd1,
    SL_RUN  = 2'd2
  } slew_st_e;

endpackage

// File: rtl/vid_stab_filter.sv
module vid_stab_filter #(
  parameter int VID_W    = 6,
  parameter int STABLE_N = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             sample_stb_i,
  input  logic [VID_W-1:0] vid_i,
  output logic [VID_W-1:0] acc_o
);
  localparam int CW = $clog2(STABLE_N + 1);

  logic [VID_W-1:0] cand_q, acc_q;
  logic [CW-1:0]    cnt_q, cnt_nxt;

  // run length of the sample being presented, saturating
  always_comb begin
    if (vid_i == cand_q)
      cnt_nxt = (cnt_q == CW'(STABLE_N)) ? cnt_q : cnt_q + 1'b1;
    else
      cnt_nxt = CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (load_i) begin
      cand_q <= vid_i;
      cnt_q  <= CW'(STABLE_N);
      acc_q  <= vid_i;
    end else if (sample_stb_i) begin
      cand_q <= vid_i;
      cnt_q  <= cnt_nxt;
      if (cnt_nxt == CW'(STABLE_N) && vid_i != acc_q) acc_q <= vid_i;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/vid_slew_unit.sv
module vid_slew_unit
  import vid_ref_pkg::*;
#(
  parameter int REF_W  = 8,
  parameter int HALF_N = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             slew_i,
  input  logic             sample_stb_i,
  input  logic             phase_tick_i,
  input  logic [REF_W-1:0] tgt_i,
  output logic [REF_W-1:0] ref_o
);
  localparam int DW = $clog2(HALF_N + 1);

  slew_st_e         st_q;
  logic [DW-1:0]    dly_q;
  logic [REF_W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SL_IDLE;
      dly_q <= '0;
      ref_q <= '0;
    end else if (load_i || !slew_i) begin
      st_q  <= SL_IDLE;
      dly_q <= '0;
      ref_q <= tgt_i;
    end else begin
      unique case (st_q)
        SL_IDLE: if (ref_q != tgt_i) begin
          st_q  <= SL_WAIT;
          dly_q <= DW'(HALF_N);
        end
        SL_WAIT: if (sample_stb_i) begin
          dly_q <= dly_q - 1'b1;
          if (dly_q == DW'(1)) st_q <= SL_RUN;
        end
        SL_RUN: begin
          // retarget keeps running; idle only on arrival
          if (ref_q == tgt_i)    st_q <= SL_IDLE;
          else if (phase_tick_i) ref_q <= (tgt_i > ref_q) ? ref_q + 1'b1 : ref_q - 1'b1;
        end
        default: st_q <= SL_IDLE;
      endcase
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/vid_ref_ctrl.sv
module vid_ref_ctrl #(
  parameter int VID_W         = 6,
  parameter int REF_W         = 8,
  parameter int SAMPLES_PER_C = 6,
  parameter int STABLE_N      = 3,
  parameter int JUMP_BASE     = 40,
  parameter int SLEW_BASE     = 140,
  parameter int SLEW_MUL      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_tick_i,
  input  logic             sample_stb_i,
  input  logic             mode_i,
  input  logic [VID_W-1:0] vid_i,
  output logic [REF_W-1:0] ref_o,
  output logic             busy_o
);
  localparam int HALF_N = SAMPLES_PER_C / 2;

  logic             init_q;
  logic [VID_W-1:0] acc_code, dec_src;
  logic [REF_W-1:0] tgt_code;

  function automatic logic [REF_W-1:0] decode(input logic slew, input logic [VID_W-1:0] v);
    if (slew) return REF_W'(SLEW_BASE) - REF_W'(v) * REF_W'(SLEW_MUL);
    else      return REF_W'(JUMP_BASE) + REF_W'(v);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b0;
    else         init_q <= 1'b1;
  end

  assign dec_src  = init_q ? acc_code : vid_i;
  assign tgt_code = decode(mode_i, dec_src);

  vid_stab_filter #(.VID_W(VID_W), .STABLE_N(STABLE_N)) u_filt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (!init_q),
    .sample_stb_i(sample_stb_i),
    .vid_i       (vid_i),
    .acc_o       (acc_code)
  );

  vid_slew_unit #(.REF_W(REF_W), .HALF_N(HALF_N)) u_slew (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (!init_q),
    .slew_i      (mode_i),
    .sample_stb_i(sample_stb_i),
    .phase_tick_i(phase_tick_i),
    .tgt_i       (tgt_code),
    .ref_o       (ref_o)
  );

  assign busy_o = (ref_o != tgt_code);
endmodule

// File: rtl/vid_ref_ctrl_chk.sv
module vid_ref_ctrl_chk #(
  parameter int VID_W = 6,
  parameter int REF_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             sample_stb_i,
  input logic             phase_tick_i,
  input logic [REF_W-1:0] ref_o,
  input logic             busy_o,
  input logic [REF_W-1:0] tgt_i,
  input logic [VID_W-1:0] acc_i,
  input logic             init_i
);
  p_accept_on_stb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && $past(init_i) && acc_i != $past(acc_i)) |-> $past(sample_stb_i));

  p_jump_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !mode_i) |=> (ref_o == $past(tgt_i)));

  p_unit_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && $past(init_i) && $past(mode_i)) |->
      (ref_o == $past(ref_o) || ref_o == $past(ref_o) + 1'b1 || $past(ref_o) == ref_o + 1'b1));

  p_step_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && $past(init_i) && $past(mode_i) && ref_o != $past(ref_o)) |-> $past(phase_tick_i));

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !busy_o) |=> $stable(ref_o));
endmodule

bind vid_ref_ctrl vid_ref_ctrl_chk #(.VID_W(VID_W), .REF_W(REF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .sample_stb_i(sample_stb_i),
  .phase_tick_i(phase_tick_i),
  .ref_o       (ref_o),
  .busy_o      (busy_o),
  .tgt_i       (tgt_code),
  .acc_i       (acc_code),
  .init_i      (init_q)
);

// File: tb/vid_ref_ctrl_test.sv
module vid_ref_ctrl_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_tick = 1'b0;
  logic       sample_stb = 1'b0;
  logic       mode = 1'b0;
  logic [5:0] vid = 6'd10;
  logic [7:0] ref_v;
  logic       busy;

  int n_tot = 0;
  int n_fail = 0;

  // mode, code, pad, expected settled reference
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 6'd11, 1'b0, 8'd51},
    {1'b0, 6'd13, 1'b0, 8'd53},
    {1'b0, 6'd12, 1'b0, 8'd52},
    {1'b1, 6'd12, 1'b0, 8'd116},
    {1'b1, 6'd15, 1'b0, 8'd110},
    {1'b1, 6'd10, 1'b0, 8'd120},
    {1'b1, 6'd20, 1'b0, 8'd100},
    {1'b0, 6'd20, 1'b0, 8'd60}
  };

  vid_ref_ctrl uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .phase_tick_i(phase_tick),
    .sample_stb_i(sample_stb),
    .mode_i      (mode),
    .vid_i       (vid),
    .ref_o       (ref_v),
    .busy_o      (busy)
  );

  always #(CLK_P / 2) clk = ~clk;

  // strobe every 4 clocks, tick every 24 clocks
  initial begin
    int pos = 0;
    forever begin
      @(posedge clk);
      #1;
      sample_stb = (pos % 4 == 0);
      phase_tick = (pos == 0);
      pos = (pos == 23) ? 0 : pos + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
    for (int g = 0; g < 5000 && busy; g++) @(negedge clk);
  endtask

  // change code (and optionally retarget after the first step), measure the ramp
  task automatic ramp(input logic m, input int v, input int v2, input int exp_ref,
                      input int exp_chg, input string tag);
    int chg = 0, bad = 0, ticks = 0, ticks_last = 0, stb = 0, stb_first = -1, prev;
    int guard = 0;
    @(negedge clk);
    mode = m;
    vid = 6'(v);
    while (!busy && guard < 200) begin @(negedge clk); guard++; end
    prev = ref_v;
    while (guard < 20000) begin
      if (ref_v != prev) begin
        chg++;
        if (!(ref_v == prev + 1 || ref_v + 1 == prev)) bad++;
        if (stb_first < 0) stb_first = stb;
        ticks_last = ticks;
        if (v2 >= 0 && chg == 1) vid = 6'(v2);
        prev = ref_v;
      end
      if (!busy) break;
      ticks += phase_tick;
      stb += sample_stb;
      @(negedge clk);
      guard++;
    end
    chk(ref_v == 8'(exp_ref), {tag, " R7 final ref"}, ref_v, exp_ref);
    chk(chg == exp_chg, {tag, " R6 step count"}, chg, exp_chg);
    chk(bad == 0, {tag, " R6 unit steps"}, bad, 0);
    chk(stb_first >= HALF, {tag, " R5 half-cycle wait"}, stb_first, HALF);
    chk(ticks_last >= exp_chg && ticks_last <= exp_chg + 1, {tag, " R6 tick budget"},
        ticks_last, exp_chg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tot++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    int n;
    bit saw_busy;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ref_v == 8'd50, "R1 reset load ref", ref_v, 50);
    chk(!busy, "R1 reset busy low", busy, 0);

    // R9 R4 R10: vector table walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      mode = VEC[i][15];
      vid  = VEC[i][14:9];
      settle();
      chk(ref_v == VEC[i][7:0], $sformatf("R9 vector %0d ref", i), ref_v, VEC[i][7:0]);
      chk(!busy, $sformatf("R7 vector %0d busy", i), busy, 0);
    end

    // R2 R3: exact acceptance on the third strobe, jump one clock later
    @(negedge clk);
    vid = 6'd21;
    n = sample_stb ? 1 : 0;
    while (n < 3) begin @(negedge clk); if (sample_stb) n++; end
    chk(ref_v == 8'd60, "R2 no change before third strobe", ref_v, 60);
    @(negedge clk);
    chk(busy, "R2 accepted on third strobe", busy, 1);
    chk(ref_v == 8'd60, "R3 ref one clock later", ref_v, 60);
    @(negedge clk);
    chk(ref_v == 8'd61, "R3 jump applied", ref_v, 61);
    chk(!busy, "R7 busy cleared", busy, 0);

    // R2: glitch of two matching strobes is rejected
    vid = 6'd22;
    n = sample_stb ? 1 : 0;
    while (n < 2) begin @(negedge clk); if (sample_stb) n++; end
    @(negedge clk);
    vid = 6'd21;
    saw_busy = 0;
    repeat (30) begin @(negedge clk); if (busy) saw_busy = 1; end
    chk(!saw_busy, "R2 glitch busy", saw_busy, 0);
    chk(ref_v == 8'd61, "R2 glitch ref", ref_v, 61);

    ramp(1'b1, 21, -1, 98, 37, "R10 mode switch up");
    ramp(1'b1, 30, -1, 80, 18, "R6 ramp down");
    ramp(1'b1, 28, 20, 100, 20, "R8 retarget");

    // R1: reset in mid-ramp reloads directly
    @(negedge clk);
    vid = 6'd10;
    repeat (100) @(negedge clk);
    chk(busy, "R1 ramp in progress", busy, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ref_v == 8'd120, "R1 reload after reset", ref_v, 120);
    chk(!busy, "R1 busy after reload", busy, 0);

    finish_run();
  end
endmodule